// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 40-bit physical address. The core sets `req_valid` along with the address and the access kind (write, user mode, instruction fetch). The walker accepts the request whenever it is idle.

It first checks that the address is canonical. It then reads one 64-bit entry from each of four tables, starting at the table frame held in `root_frame`. At every level it checks the entry against the access. When an entry passes but has never been marked as used, the walker writes it back with the accessed flag set and only then moves down a level. After the leaf level, or at the first level that fails, it raises `rsp_valid` for one cycle. With that pulse it returns either the physical address or a fault code and the level at which the fault was found.

Memory is reached through a simple port that allows one access at a time. The walker holds `mem_req` until the memory answers with a one-cycle `mem_ack`. On a read, the data arrives together with that acknowledge.

The walker is built around a five-state machine:
- ST_IDLE waits for a request.
- ST_FETCH reads an entry.
- ST_CHECK judges the entry.
- ST_MARK writes back the accessed flag.
- ST_REPLY presents the result.

Its transitions are:
- accept: ST_IDLE to ST_FETCH on a canonical request.
- reject: ST_IDLE to ST_REPLY on a non-canonical request.
- fetched: ST_FETCH to ST_CHECK on `mem_ack`.
- fault: ST_CHECK to ST_REPLY.
- mark: ST_CHECK to ST_MARK when the accessed flag is clear.
- descend: ST_CHECK or ST_MARK to ST_FETCH when a level passes below the leaf.
- finish: ST_CHECK or ST_MARK to ST_REPLY when the leaf level passes.
- release: ST_REPLY to ST_IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: An address is non-canonical when any of bits 63:48 differs from bit 47. Such an address gets fault code 1 at level 0, with `rsp_valid` in the cycle after acceptance and no memory access.
- R2: Each entry is read at address {table frame, 9-bit index, 3'b000}. The index for levels 0, 1, 2 and 3 is taken from virtual address bits 47:39, 38:30, 29:21 and 20:12. The level-0 table frame is `root_frame`; each deeper table frame is bits 39:12 of the entry read at the level above.
- R3: A walk that passes all four levels returns fault code 0 and `rsp_paddr` = {leaf entry bits 39:12, virtual address bits 11:0}.
- R4: An entry with bit 0 (present) clear gives fault code 2.
- R5: An entry with any of bits 51:40 set gives fault code 3.
- R6: A user-mode access (`req_user`=1) to an entry with bit 2 (user) clear gives fault code 5.
- R7: A user-mode write to an entry with bit 1 (writable) clear gives fault code 4. A supervisor write is never refused for this reason.
- R8: An instruction fetch through an entry with bit 63 set gives fault code 6 only while `nx_enable` is 1. With `nx_enable` at 0, bit 63 has no effect.
- R9: An entry that passes its checks with bit 5 (accessed) clear is written back to the same address with bit 5 set, before the next read. An entry with bit 5 already set causes no write.
- R10: `busy` is high from the cycle after acceptance up to and including the single `rsp_valid` cycle. A request presented while busy is ignored.
- R11: `mem_req` is low while idle. Once raised, it stays high with a stable address and write flag until `mem_ack`.
- R12: Faults are checked at every level in the order present, reserved, user, write, execute, and the first hit is reported. `rsp_level` gives the level (0 = top table, 3 = leaf) at which the walk stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 28 | Frame number of the top-level table |
| nx_enable | input | 1 | Global enable for the execute-disable bit |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_exec | input | 1 | Access is an instruction fetch |
| busy | output | 1 | A walk is in progress |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_fault | output | 3 | 0 ok, 1 non-canonical, 2 not present, 3 reserved, 4 write, 5 user, 6 execute |
| rsp_level | output | 2 | Level at which the walk stopped |
| rsp_paddr | output | 40 | Physical address when rsp_fault is 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 40 | Entry address |
| mem_wdata | output | 64 | Write data (entry with accessed flag set) |
| mem_ack | input | 1 | Access complete, one cycle |
| mem_rdata | input | 64 | Read data, valid with mem_ack |

## Verification
A wrong level counter or table frame shows up within one walk. It sends reads to addresses the bench never filled, and those reads come back as a not-present fault or as a wrong physical address. A lost or extra accessed-flag write shows at the memory port as a wrong write count by the end of the same walk. A machine that skips ST_REPLY or stays busy is caught at the first response, by the pulse and busy checks and by the per-walk timeout.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    localparam int VA_W      = 64;
    localparam int PA_W      = 40;
    localparam int ENT_W     = 64;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 9;
    localparam int LEVELS    = 4;
    localparam int FRAME_W   = PA_W - OFF_W;
    localparam int LVL_W     = $clog2(LEVELS);
    localparam int TOP_BIT   = OFF_W + IDX_W * LEVELS - 1;
    localparam int ESZ_W     = 3;
    localparam int BIT_PRES  = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_USR   = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_XD    = 63;
    localparam int RSV_LO    = 40;
    localparam int RSV_HI    = 51;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_NONCANON = 3'd1,
        FLT_NOTPRES  = 3'd2,
        FLT_RSVD     = 3'd3,
        FLT_WPROT    = 3'd4,
        FLT_UPROT    = 3'd5,
        FLT_XD       = 3'd6
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_MARK,
        ST_REPLY
    } state_e;
endpackage

// File: rtl/pgwalk_canon.sv
module pgwalk_canon
    import pgwalk_pkg::*;
(
    input  logic [VA_W-1:TOP_BIT] upper,
    output logic                  canon
);
    localparam int EXT_N = VA_W - 1 - TOP_BIT;
    logic [EXT_N-1:0] differs;

    for (genvar i = 0; i < EXT_N; i++) begin : g_ext
        assign differs[i] = upper[TOP_BIT + 1 + i] ^ upper[TOP_BIT];
    end

    assign canon = ~|differs;
endmodule

// File: rtl/pgwalk_index.sv
module pgwalk_index
    import pgwalk_pkg::*;
(
    input  logic [TOP_BIT:OFF_W] va,
    input  logic [LVL_W-1:0]     lvl,
    output logic [IDX_W-1:0]     idx
);
    logic [IDX_W-1:0] field [LEVELS];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign field[l] = va[OFF_W + IDX_W * (LEVELS - 1 - l) +: IDX_W];
    end

    assign idx = field[lvl];
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic                  pres,
    input  logic                  wr_ok,
    input  logic                  usr_ok,
    input  logic                  xd,
    input  logic [RSV_HI:RSV_LO]  rsvd,
    input  logic                  acc_write,
    input  logic                  acc_user,
    input  logic                  acc_exec,
    input  logic                  nx_en,
    output fault_e                fault
);
    always_comb begin
        if (!pres)                             fault = FLT_NOTPRES;
        else if (|rsvd)                        fault = FLT_RSVD;
        else if (acc_user && !usr_ok)          fault = FLT_UPROT;
        else if (acc_write && acc_user && !wr_ok) fault = FLT_WPROT;
        else if (acc_exec && nx_en && xd)      fault = FLT_XD;
        else                                   fault = FLT_NONE;
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               nx_enable,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               req_exec,
    output logic               busy,
    output logic               rsp_valid,
    output logic [2:0]         rsp_fault,
    output logic [LVL_W-1:0]   rsp_level,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PA_W-1:0]    mem_addr,
    output logic [ENT_W-1:0]   mem_wdata,
    input  logic               mem_ack,
    input  logic [ENT_W-1:0]   mem_rdata
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    state_e               state, state_nx;
    logic [LVL_W-1:0]     lvl_q;
    logic [FRAME_W-1:0]   base_q;
    logic [TOP_BIT:0]     va_q;
    logic                 wr_q, usr_q, exe_q;
    logic [ENT_W-1:0]     ent_q;
    fault_e               fault_q;
    logic [LVL_W-1:0]     flvl_q;
    logic [PA_W-1:0]      paddr_q;

    logic                 canon;
    logic [IDX_W-1:0]     idx;
    fault_e               lvl_fault;
    logic                 advance;

    pgwalk_canon i_canon (
        .upper (req_vaddr[VA_W-1:TOP_BIT]),
        .canon (canon)
    );

    pgwalk_index i_index (
        .va  (va_q[TOP_BIT:OFF_W]),
        .lvl (lvl_q),
        .idx (idx)
    );

    pgwalk_perm i_perm (
        .pres      (ent_q[BIT_PRES]),
        .wr_ok     (ent_q[BIT_WR]),
        .usr_ok    (ent_q[BIT_USR]),
        .xd        (ent_q[BIT_XD]),
        .rsvd      (ent_q[RSV_HI:RSV_LO]),
        .acc_write (wr_q),
        .acc_user  (usr_q),
        .acc_exec  (exe_q),
        .nx_en     (nx_enable),
        .fault     (lvl_fault)
    );

    // A level is passed once its entry is judged clean and its accessed flag is in memory
    assign advance = (state == ST_CHECK && lvl_fault == FLT_NONE && ent_q[BIT_ACC])
                   || (state == ST_MARK && mem_ack);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = canon ? ST_FETCH : ST_REPLY;
            ST_FETCH: if (mem_ack)   state_nx = ST_CHECK;
            ST_CHECK: begin
                if (lvl_fault != FLT_NONE) state_nx = ST_REPLY;
                else if (!ent_q[BIT_ACC])  state_nx = ST_MARK;
                else                       state_nx = (lvl_q == LAST_LVL) ? ST_REPLY : ST_FETCH;
            end
            ST_MARK:  if (mem_ack) state_nx = (lvl_q == LAST_LVL) ? ST_REPLY : ST_FETCH;
            ST_REPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            base_q  <= '0;
            va_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            exe_q   <= 1'b0;
            ent_q   <= '0;
            fault_q <= FLT_NONE;
            flvl_q  <= '0;
            paddr_q <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                va_q    <= req_vaddr[TOP_BIT:0];
                wr_q    <= req_write;
                usr_q   <= req_user;
                exe_q   <= req_exec;
                base_q  <= root_frame;
                lvl_q   <= '0;
                flvl_q  <= '0;
                paddr_q <= '0;
                fault_q <= canon ? FLT_NONE : FLT_NONCANON;
            end
            if (state == ST_FETCH && mem_ack) ent_q <= mem_rdata;
            if (state == ST_CHECK && lvl_fault != FLT_NONE) begin
                fault_q <= lvl_fault;
                flvl_q  <= lvl_q;
            end
            if (advance) begin
                flvl_q <= lvl_q;
                if (lvl_q == LAST_LVL) begin
                    paddr_q <= {ent_q[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                end else begin
                    base_q <= ent_q[PA_W-1:OFF_W];
                    lvl_q  <= lvl_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        rsp_valid = (state == ST_REPLY);
        rsp_fault = fault_q;
        rsp_level = flvl_q;
        rsp_paddr = paddr_q;
        mem_req   = (state == ST_FETCH) || (state == ST_MARK);
        mem_we    = (state == ST_MARK);
        mem_addr  = {base_q, idx, {ESZ_W{1'b0}}};
        mem_wdata = ent_q;
        mem_wdata[BIT_ACC] = 1'b1;
    end
endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker
    import pgwalk_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [VA_W-1:TOP_BIT]  vaddr_hi,
    input logic                   busy,
    input logic                   rsp_valid,
    input logic [2:0]             rsp_fault,
    input logic [LVL_W-1:0]       rsp_level,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [PA_W-1:0]        mem_addr,
    input logic                   wdata_acc,
    input logic                   mem_ack
);
    logic hi_ok;
    assign hi_ok = (vaddr_hi == '0) || (vaddr_hi == '1);

    AST_NONCANON_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !hi_ok) |=> (rsp_valid && rsp_fault == 3'd1 && !mem_req)); // R1
    AST_NONCANON_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd1) |-> (rsp_level == '0)); // R12
    AST_MARK_SETS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (wdata_acc && mem_addr[2:0] == 3'b000)); // R9
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R10
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy)); // R10
    AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R11
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
endmodule

bind pgwalk_top pgwalk_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .vaddr_hi  (req_vaddr[63:47]),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_level (rsp_level),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .wdata_acc (mem_wdata[5]),
    .mem_ack   (mem_ack)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
    localparam logic [63:0] F_P   = 64'h1;
    localparam logic [63:0] F_W   = 64'h2;
    localparam logic [63:0] F_U   = 64'h4;
    localparam logic [63:0] F_A   = 64'h20;
    localparam logic [63:0] F_XD  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] F_RSV = 64'h0000_1000_0000_0000;
    localparam logic [63:0] F_ALL = F_P | F_W | F_U | F_A;
    localparam logic [27:0] ROOT  = 28'h0000100;

    logic clk = 0, rst_n = 0;
    logic nx_enable = 0, req_valid = 0, req_write = 0, req_user = 0, req_exec = 0;
    logic [63:0] req_vaddr = '0;
    logic busy, rsp_valid, mem_req, mem_we;
    logic [2:0] rsp_fault;
    logic [1:0] rsp_level;
    logic [39:0] rsp_paddr, mem_addr;
    logic [63:0] mem_wdata;
    logic mem_ack = 0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] mem [logic [39:0]];
    int n_rd = 0, n_wr = 0;
    int checks = 0, errors = 0;
    int cycles = 0;
    logic [27:0] frames [4];

    always #5 clk = ~clk;

    pgwalk_top i_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .root_frame(ROOT), .nx_enable(nx_enable),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_user(req_user), .req_exec(req_exec), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: answers a held request at the following negedge, one access at a time
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 0;
            else if (mem_req) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
                    n_rd++;
                end
                mem_ack = 1;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL R10 watchdog expired: actual running, expected finished");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] ent_addr(input logic [27:0] fr, input logic [63:0] va, input int l);
        logic [8:0] ix;
        ix = va[47 - 9*l -: 9];
        return {fr, ix, 3'b000};
    endfunction

    // Fill the path of va: level l entry gets flags fl[l] and points at frames[l]
    task automatic build(input logic [63:0] va, input logic [63:0] f0, input logic [63:0] f1,
                         input logic [63:0] f2, input logic [63:0] f3, input bit rnd);
        logic [63:0] fl [4];
        logic [27:0] base;
        fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
        mem.delete();
        base = ROOT;
        for (int l = 0; l < 4; l++) begin
            frames[l] = rnd ? 28'($urandom) | 28'h1000 : 28'h200 + 28'(l * 17);
            mem[ent_addr(base, va, l)] = fl[l] | {24'h0, frames[l], 12'h0};
            base = frames[l];
        end
    endtask

    // Expected result from the requirements
    task automatic model(input logic [63:0] va, input bit w, input bit u, input bit x, input bit nx,
                         output logic [2:0] code, output logic [1:0] lvl,
                         output logic [39:0] pa, output int nwr);
        logic [27:0] base;
        logic [63:0] e;
        logic [39:0] a;
        code = 0; lvl = 0; pa = 0; nwr = 0;
        if (va[63:48] != {16{va[47]}}) begin code = 1; return; end
        base = ROOT;
        for (int l = 0; l < 4; l++) begin
            a = ent_addr(base, va, l);
            e = mem.exists(a) ? mem[a] : 64'h0;
            lvl = 2'(l);
            if (!e[0])                 code = 2;
            else if (|e[51:40])        code = 3;
            else if (u && !e[2])       code = 5;
            else if (w && u && !e[1])  code = 4;
            else if (x && nx && e[63]) code = 6;
            if (code != 0) return;
            if (!e[5]) nwr++;
            base = e[39:12];
        end
        pa = {base, va[11:0]};
    endtask

    task automatic walk(input logic [63:0] va, input bit w, input bit u, input bit x,
                        input bit hold, input string tag);
        logic [2:0] ecode; logic [1:0] elvl; logic [39:0] epa; int enwr;
        int wait_n;
        model(va, w, u, x, nx_enable, ecode, elvl, epa, enwr);
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        req_vaddr = va; req_write = w; req_user = u; req_exec = x; req_valid = 1;
        @(negedge clk);
        if (hold) req_vaddr = va ^ 64'h0000_0040_2010_0000;
        else req_valid = 0;
        check(busy === 1'b1, {"R10 busy after accept ", tag}, 64'(busy), 64'h1);
        wait_n = 0;
        while (rsp_valid !== 1'b1 && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        req_valid = 0;
        check(rsp_fault === ecode, {"R12 fault code ", tag}, 64'(rsp_fault), 64'(ecode));
        if (ecode != 0)
            check(rsp_level === elvl, {"R12 fault level ", tag}, 64'(rsp_level), 64'(elvl));
        else
            check(rsp_paddr === epa, {"R3 paddr ", tag}, 64'(rsp_paddr), 64'(epa));
        check(n_wr == enwr, {"R9 accessed writes ", tag}, 64'(n_wr), 64'(enwr));
        if (ecode == 1)
            check(n_rd == 0, {"R1 no memory read ", tag}, 64'(n_rd), 64'h0);
        @(negedge clk);
        check(busy === 1'b0 && rsp_valid === 1'b0, {"R10 release ", tag}, 64'({busy, rsp_valid}), 64'h0);
    endtask

    initial begin
        logic [63:0] va;
        logic [63:0] fl [4];
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy === 0 && rsp_valid === 0 && mem_req === 0, "R11 reset idle",
              64'({busy, rsp_valid, mem_req}), 64'h0);

        // R1 non-canonical upper bits
        walk(64'h0001_0000_0000_0000, 0, 0, 0, 0, "R1 low half bit48");
        walk(64'hFFFF_0000_0000_0000, 0, 0, 0, 0, "R1 high half bit47 clear");
        // R2 R3 canonical high-half address, full permissions
        va = 64'hFFFF_8123_4567_89AB;
        build(va, F_ALL, F_ALL, F_ALL, F_ALL, 0);
        walk(va, 1, 1, 1, 0, "R3 high half ok");
        // R9 accessed flags clear everywhere: four writes and flag set in memory
        va = 64'h0000_7F00_1234_5FFF;
        build(va, F_P|F_W|F_U, F_P|F_W|F_U, F_P|F_W|F_U, F_P|F_W|F_U, 0);
        walk(va, 0, 0, 0, 0, "R9 all clear");
        check(mem[ent_addr(frames[2], va, 3)][5] === 1'b1, "R9 leaf accessed set",
              64'(mem[ent_addr(frames[2], va, 3)][5]), 64'h1);
        // R8 execute-disable at level 2
        va = 64'h0000_0012_3456_7000;
        build(va, F_ALL, F_ALL, F_ALL | F_XD, F_ALL, 0);
        nx_enable = 1;
        walk(va, 0, 0, 1, 0, "R8 nx on");
        nx_enable = 0;
        walk(va, 0, 0, 1, 0, "R8 nx off ignored");
        // R7 read-only leaf: supervisor write allowed, user write refused
        va = 64'h0000_0000_4000_2000;
        build(va, F_ALL, F_ALL, F_ALL, F_P | F_U | F_A, 0);
        walk(va, 1, 0, 0, 0, "R7 supervisor write");
        walk(va, 1, 1, 0, 0, "R7 user write");
        // R6 user access through supervisor-only level 0
        build(va, F_P | F_W | F_A, F_ALL, F_ALL, F_ALL, 0);
        walk(va, 0, 1, 0, 0, "R6 user at level0");
        // R5 reserved bit at level 1, also ranks above user fault
        build(va, F_ALL, F_P | F_A | F_RSV, F_ALL, F_ALL, 0);
        walk(va, 0, 1, 0, 0, "R5 reserved level1");
        // R4 not present at leaf
        build(va, F_ALL, F_ALL, F_ALL, F_W | F_U, 0);
        walk(va, 0, 0, 0, 0, "R4 leaf absent");
        // R10 request held with another address while busy is ignored
        va = 64'h0000_1111_2222_3333;
        build(va, F_ALL, F_ALL, F_ALL, F_ALL, 0);
        walk(va, 0, 0, 0, 1, "R10 held request");

        // Random walks over random paths
        for (int t = 0; t < 300; t++) begin
            va = {$urandom, $urandom};
            if ($urandom % 8 != 0) va[63:48] = {16{va[47]}};
            for (int l = 0; l < 4; l++) begin
                fl[l] = (($urandom % 16) != 0 ? F_P : 64'h0)
                      | (($urandom % 3) != 0 ? F_W : 64'h0)
                      | (($urandom % 3) != 0 ? F_U : 64'h0)
                      | (($urandom % 2) != 0 ? F_A : 64'h0)
                      | (($urandom % 4) == 0 ? F_XD : 64'h0)
                      | (($urandom % 20) == 0 ? F_RSV : 64'h0);
            end
            build(va, fl[0], fl[1], fl[2], fl[3], 1);
            nx_enable = 1'($urandom);
            walk(va, 1'($urandom), 1'($urandom), 1'($urandom), 0, "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule